// File: doc/BRIEF.md
# Strided Write Traffic Generator

This block is the write half of a memory test engine. It is handed a task (a base address, a transaction count, a burst length in bytes, a stride and a power-of-two working-set size) and issues write bursts on an AXI3-style write address, write data and write response interface. The bursts walk through the working set, advancing by the stride and wrapping back to the base. It keeps the address and data channels driven for as long as work remains, and it counts responses so that completion means every write has landed. It also reports the busy time of the task in clock cycles, which is the basis for a throughput figure, and a sticky flag that records any response that was not OKAY.

The engine runs in the clock of its memory port and serves one task at a time. A state machine with three states controls it. `ST_IDLE` waits for a task and accepts it (transition IDLE to ISSUE). `ST_ISSUE` drives address and data bursts and moves on (ISSUE to DRAIN) once both channels have carried all N bursts. `ST_DRAIN` waits for the last response, then raises done and goes back (DRAIN to IDLE). The address offset is kept as a running sum of the stride, masked with W-1. No multiplier or divider is needed.

Top module: `stride_wr_gen`

## Requirements
- R1: While reset is low and right after it, task_ready is 1, awvalid and wvalid are 0, and done, err and cycles are 0.
- R2: A task is accepted only on a clock edge where task_ready and task_valid are both 1. task_ready then drops to 0 until the task completes. A task_valid pulse while busy has no effect, and the running task keeps its own parameters.
- R3: The i-th write address (i counted from 0) is A + ((i × S) mod W), where W is a power of two greater than 16, S is a power of two no larger than W, and the sum is truncated to ADDR_W bits.
- R4: Every address beat carries awlen = B/32 − 1, awsize = 5 (32 bytes), and awburst = 2'b01 (INCR). B is a power of two from 32 to 512.
- R5: From the cycle after acceptance, awvalid stays high until N address handshakes have happened. While awvalid is high and awready is low, awvalid and awaddr hold their values.
- R6: wvalid stays high until N × B/32 data beats have been accepted. wlast is 1 exactly on beat B/32 − 1 of each burst. wstrb is all ones. wdata bits [31:0] carry the index of the current burst, counted from 0.
- R7: bready is 1 whenever a task is running. done rises only after N write responses have been received. done then stays 1 until the next task is accepted.
- R8: cycles equals the number of rising clock edges after the accepting edge, up to and including the edge that raises done. It holds that value while idle.
- R9: A write response with bresp other than 2'b00 (OKAY) sets err. err stays set to the end of the task and is cleared when the next task is accepted.
- R10: A task with N = 0 issues no address or data beats and completes with cycles = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory port |
| rst_n | input | 1 | Active-low synchronous reset |
| task_valid | input | 1 | Task offered |
| task_ready | output | 1 | Engine idle and able to take a task |
| task_base | input | ADDR_W | Start address A |
| task_stride | input | ADDR_W | Stride S in bytes |
| task_wset | input | ADDR_W | Working-set size W in bytes |
| task_count | input | CNT_W | Number of bursts N |
| task_bytes | input | LEN_W+6 | Burst size B in bytes |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Write address |
| awlen | output | LEN_W | Beats per burst minus one |
| awsize | output | 3 | Bytes per beat, log2 |
| awburst | output | 2 | Burst type (INCR) |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Byte strobes |
| wlast | output | 1 | Final beat of a burst |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bresp | input | 2 | Write response code |
| done | output | 1 | Last task complete |
| cycles | output | 64 | Busy cycles of the last task |
| err | output | 1 | Non-OKAY response seen in the task |

## Verification
The bench runs tasks with address, data and response channels that are always ready, and tasks where all three stall in different rhythms. The stalled runs show whether the two issue channels advance independently and whether valid and address hold while waiting. Working sets are chosen so that the address wraps several times, including a stride equal to the working set, where every burst hits the base. Burst sizes run from one beat to sixteen, which exercises wlast placement and awlen. Further tasks cover a zero count, an injected error response followed by a clean task, and a new task offered while one is running.

// File: rtl/stride_wr_pkg.sv
package stride_wr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } wg_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/wg_addr_step.sv
module wg_addr_step #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [ADDR_W-1:0] stride,
    input  logic [ADDR_W-1:0] mask,
    output logic [ADDR_W-1:0] offset
);
    // running offset; the mask keeps it inside the power-of-two window
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            offset <= '0;
        end else if (step) begin
            offset <= (offset + stride) & mask;
        end
    end
endmodule

// File: rtl/wg_beat_track.sv
module wg_beat_track #(
    parameter int LEN_W = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             fire,
    input  logic [LEN_W-1:0] last_idx,
    output logic [CNT_W-1:0] bursts,
    output logic             last
);
    logic [LEN_W-1:0] beat;

    assign last = (beat == last_idx);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            beat   <= '0;
            bursts <= '0;
        end else if (fire) begin
            if (last) begin
                beat   <= '0;
                bursts <= bursts + 1'b1;
            end else begin
                beat <= beat + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wg_resp_track.sv
module wg_resp_track
    import stride_wr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             fire,
    input  logic [1:0]       code,
    output logic [CNT_W-1:0] count,
    output logic             bad
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
            bad   <= 1'b0;
        end else if (fire) begin
            count <= count + 1'b1;
            if (code != RESP_OKAY) begin
                bad <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/stride_wr_gen.sv
module stride_wr_gen
    import stride_wr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 256,
    parameter int CNT_W  = 32,
    parameter int LEN_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  task_valid,
    output logic                  task_ready,
    input  logic [ADDR_W-1:0]     task_base,
    input  logic [ADDR_W-1:0]     task_stride,
    input  logic [ADDR_W-1:0]     task_wset,
    input  logic [CNT_W-1:0]      task_count,
    input  logic [LEN_W+5:0]      task_bytes,
    output logic                  awvalid,
    input  logic                  awready,
    output logic [ADDR_W-1:0]     awaddr,
    output logic [LEN_W-1:0]      awlen,
    output logic [2:0]            awsize,
    output logic [1:0]            awburst,
    output logic                  wvalid,
    input  logic                  wready,
    output logic [DATA_W-1:0]     wdata,
    output logic [DATA_W/8-1:0]   wstrb,
    output logic                  wlast,
    input  logic                  bvalid,
    output logic                  bready,
    input  logic [1:0]            bresp,
    output logic                  done,
    output logic [63:0]           cycles,
    output logic                  err
);
    localparam int BYTE_SHIFT = $clog2(DATA_W / 8);
    localparam int REPL       = DATA_W / CNT_W;

    wg_state_e state, state_nxt;

    logic [ADDR_W-1:0] base_r, stride_r, mask_r, offset;
    logic [CNT_W-1:0]  count_r, aw_cnt, w_bursts, resp_cnt;
    logic [LEN_W-1:0]  len_r;
    logic              done_r;
    logic [63:0]       cyc_r;

    logic accept, aw_fire, w_fire, b_fire, aw_left, w_left, finish;

    assign accept  = (state == ST_IDLE) && task_valid;
    assign aw_fire = awvalid && awready;
    assign w_fire  = wvalid && wready;
    assign b_fire  = bvalid && bready;
    assign aw_left = (aw_cnt != count_r);
    assign w_left  = (w_bursts != count_r);
    assign finish  = (state == ST_DRAIN) && (resp_cnt == count_r);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nxt = ST_ISSUE;
            ST_ISSUE: if (!aw_left && !w_left) state_nxt = ST_DRAIN;
            ST_DRAIN: if (finish) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        task_ready = 1'b0;
        awvalid    = 1'b0;
        wvalid     = 1'b0;
        bready     = 1'b0;
        unique case (state)
            ST_IDLE:  task_ready = 1'b1;
            ST_ISSUE: begin
                awvalid = aw_left;
                wvalid  = w_left;
                bready  = 1'b1;
            end
            ST_DRAIN: bready = 1'b1;
            default:  task_ready = 1'b0;
        endcase
    end

    // task registers, issue counter, timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_r   <= '0;
            stride_r <= '0;
            mask_r   <= '0;
            count_r  <= '0;
            len_r    <= '0;
            aw_cnt   <= '0;
            done_r   <= 1'b0;
            cyc_r    <= '0;
        end else if (accept) begin
            base_r   <= task_base;
            stride_r <= task_stride;
            mask_r   <= task_wset - 1'b1;
            count_r  <= task_count;
            len_r    <= LEN_W'((task_bytes - 1'b1) >> BYTE_SHIFT);
            aw_cnt   <= '0;
            done_r   <= 1'b0;
            cyc_r    <= '0;
        end else if (state != ST_IDLE) begin
            cyc_r <= cyc_r + 64'd1;
            if (aw_fire) aw_cnt <= aw_cnt + 1'b1;
            if (finish)  done_r <= 1'b1;
        end
    end

    wg_addr_step #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .step   (aw_fire),
        .stride (stride_r),
        .mask   (mask_r),
        .offset (offset)
    );

    wg_beat_track #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .fire     (w_fire),
        .last_idx (len_r),
        .bursts   (w_bursts),
        .last     (wlast)
    );

    wg_resp_track #(.CNT_W(CNT_W)) u_resp (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .fire  (b_fire),
        .code  (bresp),
        .count (resp_cnt),
        .bad   (err)
    );

    assign awaddr  = base_r + offset;
    assign awlen   = len_r;
    assign awsize  = 3'(BYTE_SHIFT);
    assign awburst = BURST_INCR;
    assign wdata   = {REPL{w_bursts}};
    assign wstrb   = '1;
    assign done    = done_r;
    assign cycles  = cyc_r;
endmodule

// File: rtl/stride_wr_gen_chk.sv
module stride_wr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              task_valid,
    input logic              task_ready,
    input logic              awvalid,
    input logic              awready,
    input logic [ADDR_W-1:0] awaddr,
    input logic [2:0]        awsize,
    input logic [1:0]        awburst,
    input logic              wvalid,
    input logic              wready,
    input logic              wlast,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              done,
    input logic              err
);
    // R2
    accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        task_ready && task_valid |=> !task_ready && !done);

    // R4
    burst_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (awsize == 3'd5) && (awburst == 2'b01));

    // R5
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && !awready |=> awvalid && $stable(awaddr));

    // R6
    w_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && !wready |=> wvalid && $stable(wlast));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> task_ready && !awvalid && !wvalid);

    // R9
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && bready && (bresp != 2'b00) |=> err);
endmodule

bind stride_wr_gen stride_wr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .task_valid (task_valid),
    .task_ready (task_ready),
    .awvalid    (awvalid),
    .awready    (awready),
    .awaddr     (awaddr),
    .awsize     (awsize),
    .awburst    (awburst),
    .wvalid     (wvalid),
    .wready     (wready),
    .wlast      (wlast),
    .bvalid     (bvalid),
    .bready     (bready),
    .bresp      (bresp),
    .done       (done),
    .err        (err)
);

// File: tb/sim_stride_wr_gen.sv
module sim_stride_wr_gen;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          task_valid = 1'b0;
    logic          task_ready;
    logic [31:0]   task_base = '0, task_stride = '0, task_wset = '0;
    logic [31:0]   task_count = '0;
    logic [9:0]    task_bytes = '0;
    logic          awvalid, awready = 1'b0;
    logic [31:0]   awaddr;
    logic [3:0]    awlen;
    logic [2:0]    awsize;
    logic [1:0]    awburst;
    logic          wvalid, wready = 1'b0, wlast;
    logic [255:0]  wdata;
    logic [31:0]   wstrb;
    logic          bvalid = 1'b0, bready;
    logic [1:0]    bresp = 2'b00;
    logic          done, err;
    logic [63:0]   cycles;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    stride_wr_gen u0 (
        .clk(clk), .rst_n(rst_n), .task_valid(task_valid), .task_ready(task_ready),
        .task_base(task_base), .task_stride(task_stride), .task_wset(task_wset),
        .task_count(task_count), .task_bytes(task_bytes),
        .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
        .awsize(awsize), .awburst(awburst),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
        .bvalid(bvalid), .bready(bready), .bresp(bresp),
        .done(done), .cycles(cycles), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model state (reflects the state after the next rising edge)
    int     m_st = 0;
    longint m_A = 0, m_S = 0, m_W = 1, m_N = 0, m_B = 32;
    longint m_aw = 0, m_wb = 0, m_beat = 0, m_resp = 0, m_cyc = 0;
    bit     m_done = 0, m_err = 0;
    // memory-side responder
    int     mode = 0;
    longint inj_idx = -1;
    longint s_aw = 0, s_wb = 0, s_resp = 0;
    int     tc = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            longint exp_addr, avail;
            bit awf, wf, bf;
            tc++;
            // compare against the model
            chk(task_ready == (m_st == 0), "R2 task_ready", task_ready, m_st == 0);
            chk(awvalid == (m_st == 1 && m_aw < m_N), "R5 awvalid", awvalid, m_st == 1 && m_aw < m_N);
            chk(wvalid == (m_st == 1 && m_wb < m_N), "R6 wvalid", wvalid, m_st == 1 && m_wb < m_N);
            chk(bready == (m_st != 0), "R7 bready", bready, m_st != 0);
            chk(done == m_done, "R7 done", done, m_done);
            chk(err == m_err, "R9 err", err, m_err);
            chk(cycles == 64'(m_cyc), "R8 cycles", cycles, m_cyc);
            if (awvalid) begin
                exp_addr = (m_A + ((m_aw * m_S) % m_W)) & 64'hFFFF_FFFF;
                chk(awaddr == 32'(exp_addr), "R3 awaddr", awaddr, exp_addr);
                chk(awlen == 4'(m_B / 32 - 1), "R4 awlen", awlen, m_B / 32 - 1);
            end
            if (wvalid) begin
                chk(wlast == (m_beat == m_B / 32 - 1), "R6 wlast", wlast, m_beat == m_B / 32 - 1);
                chk(wdata[31:0] == 32'(m_wb), "R6 wdata", wdata[31:0], m_wb);
                chk(wstrb == 32'hFFFF_FFFF, "R6 wstrb", wstrb, 32'hFFFF_FFFF);
            end
            // drive the memory side for the next edge
            awready = (mode == 0) ? 1'b1 : (tc % 3 != 0);
            wready  = (mode == 0) ? 1'b1 : (tc % 2 == 0);
            avail   = ((s_aw < s_wb) ? s_aw : s_wb) - s_resp;
            bvalid  = (avail > 0) && ((mode == 0) || (tc % 4 != 1));
            bresp   = (s_resp == inj_idx) ? 2'b10 : 2'b00;
            awf = awvalid && awready;
            wf  = wvalid && wready;
            bf  = bvalid && bready;
            if (awf) s_aw++;
            if (wf && wlast) s_wb++;
            if (bf) s_resp++;
            // advance the model to the next edge
            case (m_st)
                0: if (task_valid) begin
                    m_st = 1;
                    m_A = task_base; m_S = task_stride; m_W = task_wset;
                    m_N = task_count; m_B = task_bytes;
                    m_aw = 0; m_wb = 0; m_beat = 0; m_resp = 0;
                    m_cyc = 0; m_done = 0; m_err = 0;
                end
                default: begin
                    m_cyc++;
                    if (m_st == 1 && m_aw == m_N && m_wb == m_N) m_st = 2;
                    else if (m_st == 2 && m_resp == m_N) begin
                        m_st = 0;
                        m_done = 1;
                    end
                    if (awf) m_aw++;
                    if (wf) begin
                        if (m_beat == m_B / 32 - 1) begin
                            m_beat = 0;
                            m_wb++;
                        end else m_beat++;
                    end
                    if (bf) begin
                        m_resp++;
                        if (bresp != 2'b00) m_err = 1;
                    end
                end
            endcase
        end
    end

    task automatic run_task(input longint a, input longint n, input longint b, input longint s,
                            input longint w, input int md, input longint inj, input bit repulse,
                            input string name);
        @(posedge clk); #1;
        mode = md; inj_idx = inj;
        s_aw = 0; s_wb = 0; s_resp = 0;
        task_base = 32'(a); task_stride = 32'(s); task_wset = 32'(w);
        task_count = 32'(n); task_bytes = 10'(b);
        task_valid = 1'b1;
        @(posedge clk); #1;
        task_valid = 1'b0;
        if (repulse) begin
            repeat (3) @(posedge clk);
            #1;
            task_base = 32'h7777_0000; task_count = 32'd1;
            task_valid = 1'b1;
            @(posedge clk); #1;
            task_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(s_aw == n, {"R7 address bursts ", name}, s_aw, n);
        chk(s_wb == n, {"R7 data bursts ", name}, s_wb, n);
        chk(s_resp == n, {"R7 responses ", name}, s_resp, n);
        chk(err == (inj >= 0 && inj < n), {"R9 err after ", name}, err, inj >= 0 && inj < n);
        chk(cycles == 64'(m_cyc), {"R8 cycles ", name}, cycles, m_cyc);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset values
        chk(task_ready == 1'b1, "R1 task_ready", task_ready, 1);
        chk(awvalid == 1'b0 && wvalid == 1'b0, "R1 valids", {awvalid, wvalid}, 0);
        chk(done == 1'b0 && err == 1'b0, "R1 done/err", {done, err}, 0);
        chk(cycles == 64'd0, "R1 cycles", cycles, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(task_ready == 1'b1 && done == 1'b0, "R1 after release", {task_ready, done}, 2);

        run_task(32'h1000, 8, 32, 64, 256, 0, -1, 0, "wrap single beat");
        run_task(32'h40000, 10, 128, 128, 1024, 1, -1, 0, "stalled four beat");
        run_task(32'h2000, 5, 64, 256, 256, 1, -1, 0, "stride equals set");
        run_task(32'h3000, 0, 32, 32, 64, 0, -1, 0, "zero count");
        chk(cycles == 64'd2, "R10 zero count cycles", cycles, 2);
        run_task(32'h800, 6, 512, 512, 2048, 0, 2, 0, "error response");
        run_task(32'h100, 12, 32, 32, 64, 1, -1, 1, "busy repulse");
        chk(err == 1'b0, "R9 err cleared by next task", err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule